// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Master Port

This block is the master end of a byte-wide synchronous serial link that shares a single data pin between both directions. It always drives the shift clock. Its data pin is an output while a byte goes out and is released to an input while a byte comes in. The host writes bytes into a one-deep transmit holding register. It arms reception one byte at a time through a receive-enable bit, which the block clears once the byte has arrived. It reads received bytes from a receive buffer.

The shift clock comes from a programmable divider. One bit takes 2×(div+1) system clocks. Bits travel least-significant first. Outgoing data changes when the clock falls and incoming data is sampled when the clock rises. Five sticky flags report events to the host: transmit holding register emptied, transmit byte finished, receive byte finished, error, and overrun. Each flag stays set until the host clears it.

Top module: `sync_ser_port`

## Requirements
- R1: A write to the transmit holding register while the port is idle, `run`=1 and receive enable is 0 makes the shift clock fall for the first bit no more than 4 system clocks after the write cycle. Nothing starts while receive enable is 1.
- R2: The write moves into the shift register as soon as the port can start, which sets flag bit 0 (transmit buffer empty). A byte written while another is shifting follows it with no idle gap.
- R3: Each frame is 8 bits sent LSB first. `sdat_o` changes only when `sclk_o` falls. `sclk_o` stays low for div+1 system clocks and then high for div+1 system clocks, so one bit lasts 2×(div+1) clocks.
- R4: At reset, and after the 8th bit time of a transmitted byte when no further byte is pending, `sclk_o` and `sdat_o` are both 1. When a byte finishes, flag bit 1 (transmit done) is set.
- R5: `sdat_oe` is 0 exactly while a byte is being received and 1 at all other times.
- R6: Setting receive enable with `run`=1 on an idle port starts a reception. `sdat_i` is sampled on each rising edge of `sclk_o`, and the first bit sampled is the LSB.
- R7: At the end of the 8th received bit time, the byte appears on `rx_data`, flag bit 2 (receive done) is set, receive enable returns to 0 and `sclk_o` stays high.
- R8: Clearing receive enable in the middle of a byte does not abort it. The byte completes with its data and its flags.
- R9: A transmit write during a reception is discarded. It does not disturb the received byte and does not cause a transmission afterwards.
- R10: When `ovr_chk_en`=1 and a byte completes while the previous received byte is still unread, flag bit 3 (error) and flag bit 4 (overrun) are both set. When `ovr_chk_en`=0, neither is set.
- R11: A flag stays set until the host pulses the matching bit of `flag_clr`, and the other flags are unaffected. Pulsing `rx_rd` marks the buffered byte as read, so the next completion raises no overrun.
- R12: While `run`=0, no transfer starts and both pins stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Allows transfers to start |
| rx_en_set | input | 1 | Pulse: arm reception of one byte |
| rx_en_clr | input | 1 | Pulse: drop receive enable |
| ovr_chk_en | input | 1 | Enables overrun detection |
| div | input | DIV_W | Half-period of the shift clock minus one, in system clocks |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | DATA_W | Byte to transmit |
| rx_rd | input | 1 | Host read strobe for the receive buffer |
| rx_data | output | DATA_W | Last received byte |
| rx_en | output | 1 | Current receive-enable state |
| flag_clr | input | 5 | Per-flag clear strobes |
| flags | output | 5 | Sticky flags: bit0 tx empty, bit1 tx done, bit2 rx done, bit3 error, bit4 overrun |
| sclk_o | output | 1 | Shift clock pin |
| sdat_o | output | 1 | Data pin output value |
| sdat_oe | output | 1 | Data pin output enable |
| sdat_i | input | 1 | Data pin input value |

## Verification
If the bit counter or the phase bit goes wrong, the port shows it within one frame. The scoreboard sees a byte that is too short, too long or misaligned. The fall-to-fall spacing no longer matches 2×(div+1) clocks. If the direction or receive-enable state goes wrong, `sdat_oe` drops or rises at the wrong moment, or the port sends a stray clock burst after a reception. The bench watches for both within a few bit times. Faults in the unread marker or the flag registers show up on `flags` in the clock cycle after the byte that should or should not have raised them.

// File: rtl/ser_pkg.sv
// Package: shared state encoding and flag positions for the serial port.
// Assumes: all modules of the port import this package.
package ser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2
    } ser_state_t;

    localparam int NFLAG  = 5;
    localparam int FL_TBE = 0;
    localparam int FL_TXD = 1;
    localparam int FL_RXD = 2;
    localparam int FL_ERR = 3;
    localparam int FL_OVR = 4;
endpackage

// File: rtl/ser_baud.sv
// Module: half-period tick generator for the shift clock.
// Produces one tick every div+1 clocks while enabled; restart realigns the
// count so the first half-period after a start is full length.
// Assumes: div is held constant during a frame.
module ser_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // tick marks the last clock of a half period
    assign tick = en && (cnt_q == div);

    // half-period counter, cleared when idle, restarted or wrapping
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (restart || !en)     cnt_q <= '0;
        else if (tick)               cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ser_flags.sv
// Module: sticky flag bank. A set pulse wins over a clear in the same cycle.
// Assumes: set and clr are single-cycle strobes.
module ser_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    // hold each flag until cleared by the host
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end
endmodule

// File: rtl/ser_engine.sv
// Module: frame engine. Holds the transmit holding register, the shift
// register, the bit/phase counters and the pin registers, and runs one
// direction at a time.
// Assumes: tick comes from ser_baud, enabled by busy and restarted by restart.
module ser_engine import ser_pkg::*; #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rx_en,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tick,
    input  logic              sdat_i,
    output logic              busy,
    output logic              restart,
    output logic              sclk_o,
    output logic              sdat_o,
    output logic              sdat_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              ev_load,
    output logic              ev_txdone,
    output logic              ev_rxdone
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    ser_state_t        state_q;
    logic [DATA_W-1:0] tbuf_q, sh_q, rbuf_q;
    logic              tfull_q, ph_q, sclk_q, sdat_q;
    logic [CNT_W-1:0]  bit_q;
    logic              start_rx, start_tx, end_bit, chain, tx_load, wr_ok;

    // start, end-of-frame and chaining decisions
    always_comb begin
        start_rx = (state_q == ST_IDLE) && run && rx_en;
        start_tx = (state_q == ST_IDLE) && run && !rx_en && tfull_q;
        end_bit  = busy && tick && ph_q && (bit_q == LAST_BIT);
        chain    = (state_q == ST_TX) && end_bit && run && !rx_en && tfull_q;
        tx_load  = start_tx || chain;
        wr_ok    = tx_wr && (state_q != ST_RX);
    end

    assign busy      = (state_q != ST_IDLE);
    assign restart   = start_rx || tx_load;
    assign sclk_o    = sclk_q;
    assign sdat_o    = sdat_q;
    assign sdat_oe   = (state_q != ST_RX);
    assign rx_data   = rbuf_q;
    assign ev_load   = tx_load;
    assign ev_txdone = end_bit && (state_q == ST_TX);
    assign ev_rxdone = end_bit && (state_q == ST_RX);

    // transmit holding register: loads on host write, empties on transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbuf_q  <= '0;
            tfull_q <= 1'b0;
        end else begin
            if (tx_load) tfull_q <= 1'b0;
            if (wr_ok) begin
                tbuf_q  <= tx_data;
                tfull_q <= 1'b1;
            end
        end
    end

    // frame sequencer: phases, bit count, shifting and pin values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            rbuf_q  <= '0;
            ph_q    <= 1'b0;
            bit_q   <= '0;
            sclk_q  <= 1'b1;
            sdat_q  <= 1'b1;
        end else begin
            if (busy && tick) begin
                if (!ph_q) begin
                    ph_q   <= 1'b1;
                    sclk_q <= 1'b1;
                    if (state_q == ST_RX) sh_q <= {sdat_i, sh_q[DATA_W-1:1]};
                end else if (bit_q == LAST_BIT) begin
                    state_q <= ST_IDLE;
                    sclk_q  <= 1'b1;
                    sdat_q  <= 1'b1;
                    if (state_q == ST_RX) rbuf_q <= sh_q;
                end else begin
                    bit_q  <= bit_q + 1'b1;
                    ph_q   <= 1'b0;
                    sclk_q <= 1'b0;
                    if (state_q == ST_TX) begin
                        sh_q   <= sh_q >> 1;
                        sdat_q <= sh_q[1];
                    end
                end
            end
            if (tx_load) begin
                state_q <= ST_TX;
                sh_q    <= tbuf_q;
                sdat_q  <= tbuf_q[0];
                sclk_q  <= 1'b0;
                ph_q    <= 1'b0;
                bit_q   <= '0;
            end else if (start_rx) begin
                state_q <= ST_RX;
                sdat_q  <= 1'b1;
                sclk_q  <= 1'b0;
                ph_q    <= 1'b0;
                bit_q   <= '0;
            end
        end
    end

    AST_PINS_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (sclk_q && sdat_q && sdat_oe));  // R4
    AST_SCLK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(sclk_q));  // R3
    AST_RBUF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_rxdone |=> $stable(rbuf_q));  // R7
endmodule

// File: rtl/sync_ser_port.sv
// Module: top of the half-duplex synchronous serial master port.
// Owns the receive-enable bit, the unread marker and the flag events, and
// wires the tick generator, frame engine and flag bank together.
// Assumes: host strobes are one clock wide; sdat_i is already synchronous.
module sync_ser_port import ser_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rx_en_set,
    input  logic              rx_en_clr,
    input  logic              ovr_chk_en,
    input  logic [DIV_W-1:0]  div,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_en,
    input  logic [NFLAG-1:0]  flag_clr,
    output logic [NFLAG-1:0]  flags,
    output logic              sclk_o,
    output logic              sdat_o,
    output logic              sdat_oe,
    input  logic              sdat_i
);
    logic             rx_en_q, unread_q;
    logic             tick, busy, restart;
    logic             ev_load, ev_txdone, ev_rxdone, ev_ovr;
    logic [NFLAG-1:0] fset;

    assign rx_en = rx_en_q;

    ser_baud #(.DIV_W(DIV_W)) i_baud (
        .clk(clk), .rst_n(rst_n), .en(busy), .restart(restart),
        .div(div), .tick(tick)
    );

    ser_engine #(.DATA_W(DATA_W)) i_engine (
        .clk(clk), .rst_n(rst_n), .run(run), .rx_en(rx_en_q),
        .tx_wr(tx_wr), .tx_data(tx_data), .tick(tick), .sdat_i(sdat_i),
        .busy(busy), .restart(restart), .sclk_o(sclk_o), .sdat_o(sdat_o),
        .sdat_oe(sdat_oe), .rx_data(rx_data), .ev_load(ev_load),
        .ev_txdone(ev_txdone), .ev_rxdone(ev_rxdone)
    );

    // receive enable: host arms it, host or byte completion drops it
    always_ff @(posedge clk) begin
        if (!rst_n)                      rx_en_q <= 1'b0;
        else if (rx_en_set)              rx_en_q <= 1'b1;
        else if (rx_en_clr || ev_rxdone) rx_en_q <= 1'b0;
    end

    // unread marker for the receive buffer
    always_ff @(posedge clk) begin
        if (!rst_n)         unread_q <= 1'b0;
        else if (ev_rxdone) unread_q <= 1'b1;
        else if (rx_rd)     unread_q <= 1'b0;
    end

    // overrun event and flag set vector
    always_comb begin
        ev_ovr         = ev_rxdone && ovr_chk_en && unread_q && !rx_rd;
        fset           = '0;
        fset[FL_TBE]   = ev_load;
        fset[FL_TXD]   = ev_txdone;
        fset[FL_RXD]   = ev_rxdone;
        fset[FL_ERR]   = ev_ovr;
        fset[FL_OVR]   = ev_ovr;
    end

    ser_flags #(.N(NFLAG)) i_flags (
        .clk(clk), .rst_n(rst_n), .set(fset), .clr(flag_clr), .flags(flags)
    );

    AST_RXEN_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rxdone && !rx_en_set) |=> !rx_en_q);  // R7
    AST_OVR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_OVR]) |-> $past(ovr_chk_en));  // R10
    AST_ERR_WITH_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_OVR]) |-> flags[FL_ERR]);  // R10
endmodule

// File: tb/test_sync_ser_port.sv
`timescale 1ns/1ps
module test_sync_ser_port;
    localparam int DW = 8;
    localparam int VW = 8;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          run = 1'b0, rx_en_set = 1'b0, rx_en_clr = 1'b0, ovr_chk_en = 1'b0;
    logic [VW-1:0] div = 8'd2;
    logic          tx_wr = 1'b0, rx_rd = 1'b0, sdat_i = 1'b1;
    logic [DW-1:0] tx_data = '0;
    logic [4:0]    flag_clr = '0;
    logic [DW-1:0] rx_data;
    logic [4:0]    flags;
    logic          rx_en, sclk_o, sdat_o, sdat_oe;

    int            n_chk = 0, n_bad = 0;
    logic [7:0]    exp_q[$];
    logic [7:0]    slave_byte = 8'h00;
    bit            finished = 0;

    always #2.5 clk = ~clk;

    sync_ser_port #(.DATA_W(DW), .DIV_W(VW)) i_sync_ser_port (
        .clk(clk), .rst_n(rst_n), .run(run), .rx_en_set(rx_en_set),
        .rx_en_clr(rx_en_clr), .ovr_chk_en(ovr_chk_en), .div(div),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .rx_en(rx_en), .flag_clr(flag_clr), .flags(flags), .sclk_o(sclk_o),
        .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: push the expected byte, then write it
    task automatic send(input logic [7:0] b, input bit expect_it);
        if (expect_it) exp_q.push_back(b);
        @(negedge clk); tx_data = b; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic wait_flag(input int idx);
        while (!flags[idx]) @(negedge clk);
    endtask

    task automatic wait_quiet(input int n);
        int c = 0;
        while (c < n) begin
            @(negedge clk);
            if (sclk_o && sdat_oe) c++; else c = 0;
        end
    endtask

    task automatic clr_flags(input logic [4:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic arm_rx(input logic [7:0] b);
        slave_byte = b;
        @(negedge clk); rx_en_set = 1'b1;
        @(negedge clk); rx_en_set = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    // monitor: collect bits on rising shift clock, compare with scoreboard
    initial begin
        logic       prev_s = 1'b1;
        logic [7:0] sh = '0;
        int         nb = 0;
        forever begin
            @(negedge clk);
            if (rst_n && sdat_oe && !prev_s && sclk_o) begin
                sh = {sdat_o, sh[7:1]};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    if (exp_q.size() == 0) chk_eq("R9 stray tx byte", 1, 0);
                    else chk_eq("R3 tx byte", sh, exp_q.pop_front());
                end
            end
            prev_s = sclk_o;
        end
    end

    // slave model: present the next bit after each falling clock in reception
    initial begin
        logic prev_s = 1'b1;
        logic prev_oe = 1'b1;
        int   idx = 0;
        forever begin
            @(negedge clk);
            if (prev_oe && !sdat_oe) idx = 0;
            if (!sdat_oe && prev_s && !sclk_o && idx < 8) begin
                sdat_i = slave_byte[idx];
                idx++;
            end
            prev_s  = sclk_o;
            prev_oe = sdat_oe;
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lat, per, falls;
        logic ps;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R4 reset sclk", sclk_o, 1);
        chk_eq("R4 reset sdat", sdat_o, 1);
        chk_eq("R5 reset oe", sdat_oe, 1);
        chk_eq("R11 reset flags", flags, 0);

        // R12: no start while run is low
        send(8'h55, 1'b1);
        falls = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!sclk_o || !sdat_o) falls++;
        end
        chk_eq("R12 idle while run=0", falls, 0);
        run = 1'b1;
        wait_quiet(20);
        chk_eq("R12 byte sent after run", exp_q.size(), 0);
        clr_flags(5'h1f);

        // R1 latency and R3 period with div=2
        send(8'hA5, 1'b1);
        lat = 1;
        while (sclk_o) begin @(negedge clk); lat++; end
        chk_eq("R1 start latency<=4", (lat <= 4) ? 1 : 0, 1);
        per = 0;
        do begin @(negedge clk); per++; end while (!sclk_o);
        do begin @(negedge clk); per++; end while (sclk_o);
        chk_eq("R3 bit period div=2", per, 6);
        chk_eq("R2 tbe flag", flags[0], 1);
        wait_flag(1);
        @(negedge clk);
        chk_eq("R4 sclk parked", sclk_o, 1);
        chk_eq("R4 sdat parked", sdat_o, 1);
        chk_eq("R4 txdone flag", flags[1], 1);
        wait_quiet(20);

        // R2 back to back
        clr_flags(5'h1f);
        send(8'h3C, 1'b1);
        wait_flag(0);
        send(8'hC3, 1'b1);
        wait_flag(1);
        clr_flags(5'h02);
        ps = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (sclk_o && sdat_oe && flags[1] == 1'b0 && exp_q.size() == 1) ps = ps;
        end
        wait_quiet(20);
        chk_eq("R2 both bytes sent", exp_q.size(), 0);

        // R3 period with div=0
        div = 8'd0;
        send(8'h81, 1'b1);
        while (sclk_o) @(negedge clk);
        per = 0;
        do begin @(negedge clk); per++; end while (!sclk_o);
        do begin @(negedge clk); per++; end while (sclk_o);
        chk_eq("R3 bit period div=0", per, 2);
        wait_quiet(10);

        // R5/R6/R7 reception with div=1
        div = 8'd1;
        clr_flags(5'h1f);
        arm_rx(8'h6B);
        @(negedge clk);
        chk_eq("R5 oe low in rx", sdat_oe, 0);
        wait_flag(2);
        @(negedge clk);
        chk_eq("R6 rx data", rx_data, 8'h6B);
        chk_eq("R7 rx_en cleared", rx_en, 0);
        chk_eq("R5 oe restored", sdat_oe, 1);
        chk_eq("R7 sclk high", sclk_o, 1);

        // R8 clear rx enable mid-byte; R10 no overrun with check off
        clr_flags(5'h1f);
        arm_rx(8'h9E);
        repeat (6) @(negedge clk);
        @(negedge clk); rx_en_clr = 1'b1;
        @(negedge clk); rx_en_clr = 1'b0;
        chk_eq("R8 rx_en dropped", rx_en, 0);
        wait_flag(2);
        @(negedge clk);
        chk_eq("R8 byte completed", rx_data, 8'h9E);
        chk_eq("R10 no err with check off", flags[3], 0);
        chk_eq("R10 no ovr with check off", flags[4], 0);

        // R9 transmit write during reception is discarded
        read_rx();
        clr_flags(5'h1f);
        arm_rx(8'h2D);
        repeat (4) @(negedge clk);
        send(8'h77, 1'b0);
        wait_flag(2);
        falls = 0;
        ps = sclk_o;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (ps && !sclk_o) falls++;
            ps = sclk_o;
        end
        chk_eq("R9 no tx after rx", falls, 0);
        chk_eq("R9 rx data intact", rx_data, 8'h2D);
        chk_eq("R9 no load flag", flags[0], 0);

        // R10 overrun with check on (previous byte unread)
        ovr_chk_en = 1'b1;
        clr_flags(5'h1f);
        arm_rx(8'h4F);
        wait_flag(2);
        @(negedge clk);
        chk_eq("R10 err flag", flags[3], 1);
        chk_eq("R10 ovr flag", flags[4], 1);
        chk_eq("R10 data", rx_data, 8'h4F);

        // R11 selective clear and read marker
        clr_flags(5'h10);
        chk_eq("R11 ovr cleared", flags[4], 0);
        chk_eq("R11 err kept", flags[3], 1);
        clr_flags(5'h1f);
        read_rx();
        arm_rx(8'h10);
        wait_flag(2);
        @(negedge clk);
        chk_eq("R11 no ovr after read", flags[4], 0);
        chk_eq("R11 no err after read", flags[3], 0);
        chk_eq("R6 rx data 2", rx_data, 8'h10);

        chk_eq("R3 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule